// File: doc/BRIEF.md
# Asynchronous Bus Cycle Sequencer

This block is a bus master that runs one read or one write on an asynchronous bus, where the slave ends each transfer with an active-low acknowledge. A cycle is split into eight half-clock states, S0 to S7, which always come in that order. The block runs on a clock at twice the bus rate, so each state lasts one tick. From these states it drives the address, the read/write line, the address strobe, the data strobe and the write-data enable.

A client starts a cycle by pulsing `start_i` together with an address, a direction and, for a write, the data. The sequencer checks the synchronised acknowledge in S4. If acknowledge is not there, it adds wait states of two ticks each and checks again. With no other termination it waits indefinitely.

A cycle can end in one of three ways:
- an acknowledge;
- an external bus error;
- an internal timeout, raised when a parameterised count of wait states runs out. A limit of zero turns the timeout off.

When the cycle ends, `done_o` pulses for one tick. It comes with the captured read data, or with `err_o` if the cycle was aborted. A reset ends any cycle at once.

Top module: `abus_master`

## Requirements
- R1: While reset is asserted and right after it, both strobes are negated (high), read/write shows read (1), the data enable is low and `done_o` is low.
- R2: The tick after the clock edge that takes `start_i` in idle is S0. With acknowledge low from S2 onward, `done_o` is high in the tick that follows the 8th edge after that start edge.
- R3: Address and read/write are valid from S1, and the address stays stable while the address strobe is low. The address strobe goes low at S2. For a read the data strobe also goes low at S2. For a write the data enable goes high at S3 and the data strobe goes low at S4. The data strobe is never low while the address strobe is high.
- R4: Acknowledge and bus error each pass through two flops before they are used. If acknowledge goes low d ticks after the address strobe falls, the sequencer adds ceil(d/2) wait states of two ticks each. `done_o` then follows edge 8 + 2*ceil(d/2).
- R5: In a read, the data input is captured at S6 and shown on `rdata_o` while `done_o` is high, with `err_o` low.
- R6: In a write, the data enable stays high through S7 and the tick after it (the done tick). It goes low one tick later.
- R7: A bus error seen at an S4 check overrides acknowledge. The sequencer jumps to S7 with both strobes negated, and `done_o` and `err_o` then pulse together. With bus error low from S2, this happens after edge 6. `err_o` is never high without `done_o`.
- R8: With a timeout limit L > 0, a cycle that has already added L wait states is aborted as a bus error at its next S4 check if acknowledge is still missing (done after edge 6 + 2L). An acknowledge at that same check still completes the cycle normally.
- R9: With a limit of 0, a cycle with no acknowledge and no bus error keeps the address strobe low and never raises `done_o`.
- R10: A `start_i` pulse during a cycle is ignored: the address and the cycle length stay unchanged, and no second cycle follows.
- R11: Asserting reset in the middle of a cycle negates both strobes and leaves the block idle.
- R12: `done_o` is high for exactly one tick. Both strobes are negated at S7 on the same edge, and they are high while `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock, twice the bus rate; one S-state per tick |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, taken only when idle |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Request address |
| wdata_i | input | DW | Write data |
| done_o | output | 1 | One-tick completion pulse |
| err_o | output | 1 | Cycle ended by bus error or timeout |
| rdata_o | output | DW | Captured read data |
| bus_addr_o | output | AW | Bus address |
| bus_rw_o | output | 1 | Bus direction, 1 = read |
| bus_as_no | output | 1 | Address strobe, active low |
| bus_ds_no | output | 1 | Data strobe, active low |
| bus_data_i | input | DW | Bus data in |
| bus_data_o | output | DW | Bus data out |
| bus_data_oe_o | output | 1 | Bus data output enable |
| bus_ack_ni | input | 1 | Transfer acknowledge, active low, asynchronous |
| bus_berr_ni | input | 1 | Bus error, active low, asynchronous |

## Verification
The checker assumes that the slave plays by the handshake. It asserts acknowledge or bus error only while the address strobe is low, and it releases them once the cycle completes. The checker also assumes that read data is stable from the acknowledge until S6. The bench's slave model drives acknowledge, bus error and data only after it has seen the address strobe fall, counting a set number of ticks from that point. It releases all of them in the done tick and leaves a gap of idle ticks before the next request, so the synchronisers drain. The only request the bench raises outside idle is the one that R10 tests on purpose.

// File: rtl/abus_pkg.sv
package abus_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_S0, ST_S1, ST_S2, ST_S3, ST_S4, ST_S5, ST_S6, ST_S7, ST_SW
  } bus_state_e;
endpackage

// File: rtl/abus_sync.sv
module abus_sync #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/abus_watchdog.sv
module abus_watchdog #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic expire_o
);
  if (LIMIT == 0) begin : g_off
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, clr_i, tick_i};
    assign expire_o  = 1'b0;
  end else begin : g_on
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   cnt_q <= '0;
      else if (clr_i)                cnt_q <= '0;
      else if (tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end

    assign expire_o = (cnt_q == LIM);
  end
endmodule

// File: rtl/abus_strobe_gen.sv
module abus_strobe_gen
  import abus_pkg::*;
(
  input  bus_state_e st_i,
  input  logic       wr_i,
  output logic       as_no,
  output logic       ds_no,
  output logic       rw_o,
  output logic       drive_o
);
  logic addr_phase, strobe_phase, wdata_phase, wds_phase;

  always_comb begin
    addr_phase   = 1'b0;
    strobe_phase = 1'b0;
    wdata_phase  = 1'b0;
    wds_phase    = 1'b0;
    unique case (st_i)
      ST_S1:              addr_phase = 1'b1;
      ST_S2:              begin addr_phase = 1'b1; strobe_phase = 1'b1; end
      ST_S3:              begin addr_phase = 1'b1; strobe_phase = 1'b1; wdata_phase = 1'b1; end
      ST_S4, ST_SW,
      ST_S5, ST_S6:       begin addr_phase = 1'b1; strobe_phase = 1'b1; wdata_phase = 1'b1; wds_phase = 1'b1; end
      ST_S7:              begin addr_phase = 1'b1; wdata_phase = 1'b1; end
      default:            ;
    endcase
  end

  assign as_no   = !strobe_phase;
  // write data strobe waits for data to settle a tick
  assign ds_no   = wr_i ? !wds_phase : !strobe_phase;
  assign rw_o    = !(addr_phase && wr_i);
  assign drive_o = wdata_phase && wr_i;
endmodule

// File: rtl/abus_master.sv
module abus_master
  import abus_pkg::*;
#(
  parameter int unsigned AW       = 24,
  parameter int unsigned DW       = 16,
  parameter int unsigned WD_LIMIT = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_rw_o,
  output logic          bus_as_no,
  output logic          bus_ds_no,
  input  logic [DW-1:0] bus_data_i,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_data_oe_o,
  input  logic          bus_ack_ni,
  input  logic          bus_berr_ni
);
  bus_state_e st_q, st_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          wr_q, abort_q, done_q, err_q, rel_q;
  logic [1:0]    term_n;
  logic          ack_s, berr_s, wd_exp, drive;
  logic          accept, abort_set;

  abus_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({bus_berr_ni, bus_ack_ni}),
    .q_o   (term_n)
  );
  assign ack_s  = !term_n[0];
  assign berr_s = !term_n[1];

  abus_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_q != ST_S4 && st_q != ST_SW),
    .tick_i  (st_q == ST_S4 && st_d == ST_SW),
    .expire_o(wd_exp)
  );

  assign accept = start_i && (st_q == ST_IDLE);

  always_comb begin
    st_d      = st_q;
    abort_set = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_S0;
      ST_S0:   st_d = ST_S1;
      ST_S1:   st_d = ST_S2;
      ST_S2:   st_d = ST_S3;
      ST_S3:   st_d = ST_S4;
      ST_S4: begin
        // bus error beats acknowledge; acknowledge beats timeout
        if (berr_s)      begin st_d = ST_S7; abort_set = 1'b1; end
        else if (ack_s)  st_d = ST_S5;
        else if (wd_exp) begin st_d = ST_S7; abort_set = 1'b1; end
        else             st_d = ST_SW;
      end
      ST_SW:   st_d = ST_S4;
      ST_S5:   st_d = ST_S6;
      ST_S6:   st_d = ST_S7;
      ST_S7:   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      abort_q <= 1'b0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rel_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        wr_q    <= write_i;
        abort_q <= 1'b0;
      end else if (abort_set) begin
        abort_q <= 1'b1;
      end
      if (st_q == ST_S6 && !wr_q) rdata_q <= bus_data_i;
      done_q <= (st_q == ST_S7);
      err_q  <= (st_q == ST_S7) && abort_q;
      rel_q  <= (st_q == ST_S7) && wr_q;
    end
  end

  abus_strobe_gen u_strb (
    .st_i   (st_q),
    .wr_i   (wr_q),
    .as_no  (bus_as_no),
    .ds_no  (bus_ds_no),
    .rw_o   (bus_rw_o),
    .drive_o(drive)
  );

  assign bus_addr_o    = addr_q;
  assign bus_data_o    = wdata_q;
  assign bus_data_oe_o = drive || rel_q;
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign rdata_o       = rdata_q;
endmodule

// File: rtl/abus_master_chk.sv
module abus_master_chk #(
  parameter int unsigned AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic          err_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_as_no,
  input logic          bus_ds_no
);
  // R3
  ds_needs_as_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_ds_no |-> !bus_as_no);

  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_as_no && $past(!bus_as_no)) |-> $stable(bus_addr_o));

  // R12
  strobes_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_as_no) |-> bus_ds_no);

  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R12
  done_idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (bus_as_no && bus_ds_no));

  // R7
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
endmodule

bind abus_master abus_master_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .done_o    (done_o),
  .err_o     (err_o),
  .bus_addr_o(bus_addr_o),
  .bus_as_no (bus_as_no),
  .bus_ds_no (bus_ds_no)
);

// File: tb/abus_master_test.sv
`timescale 1ns/1ps
module abus_master_test;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int WDL = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0, write = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, data_in = '0;
  logic ack_n = 1'b1, berr_n = 1'b1;
  logic nw_start = 1'b0;

  logic done, err, rw, as_n, ds_n, oe;
  logic [DW-1:0] rdata, data_out;
  logic [AW-1:0] baddr;
  logic nw_done, nw_err, nw_rw, nw_as_n, nw_ds_n, nw_oe;
  logic [DW-1:0] nw_rdata, nw_dout;
  logic [AW-1:0] nw_baddr;

  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  abus_master #(.AW(AW), .DW(DW), .WD_LIMIT(WDL)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .write_i(write),
    .addr_i(addr), .wdata_i(wdata), .done_o(done), .err_o(err),
    .rdata_o(rdata), .bus_addr_o(baddr), .bus_rw_o(rw), .bus_as_no(as_n),
    .bus_ds_no(ds_n), .bus_data_i(data_in), .bus_data_o(data_out),
    .bus_data_oe_o(oe), .bus_ack_ni(ack_n), .bus_berr_ni(berr_n)
  );

  abus_master #(.AW(AW), .DW(DW), .WD_LIMIT(0)) uut_nowd (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(nw_start), .write_i(1'b0),
    .addr_i(addr), .wdata_i(wdata), .done_o(nw_done), .err_o(nw_err),
    .rdata_o(nw_rdata), .bus_addr_o(nw_baddr), .bus_rw_o(nw_rw), .bus_as_no(nw_as_n),
    .bus_ds_no(nw_ds_n), .bus_data_i(data_in), .bus_data_o(nw_dout),
    .bus_data_oe_o(nw_oe), .bus_ack_ni(ack_n), .bus_berr_ni(berr_n)
  );

  // per-tick traces of the last run
  logic as_tr [0:63];
  logic ds_tr [0:63];
  logic oe_tr [0:63];
  logic dn_tr [0:63];
  logic [AW-1:0] ad_tr [0:63];
  logic [DW-1:0] do_tr [0:63];
  int done_k;
  logic err_s;
  logic [DW-1:0] rdata_s;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input longint act, input longint exp);
    check(act == exp, req, act, exp);
  endtask

  // mode 0: acknowledge, 1: bus error, 2: no response
  task automatic run_cycle(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                           input int d, input int mode, input logic [DW-1:0] rd, input int glitch_k);
    int tas;
    tas = -1;
    done_k = -1;
    for (int i = 0; i < 64; i++) begin
      as_tr[i] = 1'b1; ds_tr[i] = 1'b1; oe_tr[i] = 1'b0; dn_tr[i] = 1'b0;
      ad_tr[i] = '0; do_tr[i] = '0;
    end
    @(negedge clk);
    write = wr; addr = a; wdata = wd; start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    for (int k = 1; k < 63; k++) begin
      @(posedge clk);
      #1 start = 1'b0;
      @(negedge clk);
      as_tr[k] = as_n; ds_tr[k] = ds_n; oe_tr[k] = oe; dn_tr[k] = done;
      ad_tr[k] = baddr; do_tr[k] = data_out;
      if (tas < 0 && !as_n) tas = k;
      if (tas >= 0 && k == tas + d) begin
        if (mode == 0) begin ack_n = 1'b0; data_in = rd; end
        if (mode == 1) berr_n = 1'b0;
      end
      if (k == glitch_k) begin
        start = 1'b1; addr = ~a; write = ~wr;
      end
      if (done) begin
        done_k = k; err_s = err; rdata_s = rdata;
        ack_n = 1'b1; berr_n = 1'b1;
        @(negedge clk);
        as_tr[k+1] = as_n; ds_tr[k+1] = ds_n; oe_tr[k+1] = oe; dn_tr[k+1] = done;
        break;
      end
    end
    ack_n = 1'b1; berr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk_eq("R1 as_n in reset", as_n, 1);
    chk_eq("R1 ds_n in reset", ds_n, 1);
    chk_eq("R1 done in reset", done, 0);
    chk_eq("R1 oe in reset", oe, 0);
    chk_eq("R1 rw in reset", rw, 1);
    @(negedge clk); rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk_eq("R1 as_n after reset", as_n, 1);
    chk_eq("R1 done after reset", done, 0);
  endtask

  task automatic t_read_nowait;
    run_cycle(1'b0, 24'h12_3456, '0, 0, 0, 16'hA5C3, 0);
    chk_eq("R2 read done tick", done_k, 8);
    chk_eq("R3 as high at S1", as_tr[1], 1);
    chk_eq("R3 as low at S2", as_tr[2], 0);
    chk_eq("R3 read ds low at S2", ds_tr[2], 0);
    chk_eq("R3 address at S1", ad_tr[1], 24'h12_3456);
    chk_eq("R5 read data", rdata_s, 16'hA5C3);
    chk_eq("R5 no error", err_s, 0);
    chk_eq("R12 as negated at S7", as_tr[7], 1);
    chk_eq("R12 ds negated at S7", ds_tr[7], 1);
    chk_eq("R12 done one tick", dn_tr[9], 0);
  endtask

  task automatic t_write_nowait;
    run_cycle(1'b1, 24'h00_0ABC, 16'h5A17, 0, 0, '0, 0);
    chk_eq("R2 write done tick", done_k, 8);
    chk_eq("R3 oe low at S2", oe_tr[2], 0);
    chk_eq("R3 oe high at S3", oe_tr[3], 1);
    chk_eq("R3 write data at S3", do_tr[3], 16'h5A17);
    chk_eq("R3 write ds high at S3", ds_tr[3], 1);
    chk_eq("R3 write ds low at S4", ds_tr[4], 0);
    chk_eq("R6 as negated at S7", as_tr[7], 1);
    chk_eq("R6 oe held at S7", oe_tr[7], 1);
    chk_eq("R6 oe held in done tick", oe_tr[8], 1);
    chk_eq("R6 oe released after", oe_tr[9], 0);
  endtask

  task automatic t_waits;
    run_cycle(1'b0, 24'h00_0100, '0, 3, 0, 16'h0F0F, 0);
    chk_eq("R4 d=3 done tick", done_k, 12);
    chk_eq("R4 strobe held in wait", ds_tr[9], 0);
    chk_eq("R5 read data after waits", rdata_s, 16'h0F0F);
    run_cycle(1'b0, 24'h00_0200, '0, 5, 0, 16'h1234, 0);
    chk_eq("R4 d=5 done tick", done_k, 14);
    run_cycle(1'b1, 24'h00_0300, 16'hBEEF, 2, 0, '0, 0);
    chk_eq("R4 write d=2 done tick", done_k, 10);
    chk_eq("R4 write no error", err_s, 0);
  endtask

  task automatic t_berr;
    run_cycle(1'b0, 24'h00_0400, '0, 0, 1, '0, 0);
    chk_eq("R7 berr done tick", done_k, 6);
    chk_eq("R7 berr flag", err_s, 1);
    chk_eq("R7 as negated on abort", as_tr[5], 1);
    chk_eq("R7 ds negated on abort", ds_tr[5], 1);
    run_cycle(1'b1, 24'h00_0500, 16'h1111, 2, 1, '0, 0);
    chk_eq("R7 late berr done tick", done_k, 8);
    chk_eq("R7 late berr flag", err_s, 1);
  endtask

  task automatic t_watchdog;
    run_cycle(1'b0, 24'h00_0600, '0, 0, 2, '0, 0);
    chk_eq("R8 timeout done tick", done_k, 6 + 2*WDL);
    chk_eq("R8 timeout flag", err_s, 1);
    run_cycle(1'b0, 24'h00_0700, '0, 2*WDL, 0, 16'h7777, 0);
    chk_eq("R8 ack at limit done tick", done_k, 8 + 2*WDL);
    chk_eq("R8 ack at limit no error", err_s, 0);
  endtask

  task automatic t_forever;
    bit seen;
    seen = 1'b0;
    @(negedge clk); nw_start = 1'b1;
    @(posedge clk); #1 nw_start = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (nw_done) seen = 1'b1;
    end
    chk_eq("R9 no done without ack", seen, 0);
    chk_eq("R9 strobe still low", nw_as_n, 0);
    berr_n = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (nw_done) begin seen = 1'b1; chk_eq("R9 ended by berr", nw_err, 1); end
    end
    berr_n = 1'b1;
    chk_eq("R9 berr ends wait", seen, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_busy_start;
    bit extra;
    extra = 1'b0;
    run_cycle(1'b0, 24'h00_0A0A, '0, 0, 0, 16'h4242, 3);
    chk_eq("R10 cycle length unchanged", done_k, 8);
    chk_eq("R10 address unchanged", ad_tr[5], 24'h00_0A0A);
    chk_eq("R10 read data", rdata_s, 16'h4242);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!as_n) extra = 1'b1;
    end
    chk_eq("R10 no second cycle", extra, 0);
  endtask

  task automatic t_reset_mid;
    @(negedge clk); write = 1'b0; addr = 24'h00_0B0B; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (7) @(negedge clk);
    chk_eq("R11 strobe low before reset", as_n, 0);
    rst_ni = 1'b0;
    #1;
    chk_eq("R11 as negated by reset", as_n, 1);
    chk_eq("R11 ds negated by reset", ds_n, 1);
    @(negedge clk); rst_ni = 1'b1;
    repeat (6) @(negedge clk);
    chk_eq("R11 stays idle", as_n, 1);
    chk_eq("R11 no done", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_read_nowait();
    t_write_nowait();
    t_waits();
    t_berr();
    t_watchdog();
    t_forever();
    t_busy_start();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule